// File: doc/BRIEF.md
# 16-bit arithmetic group decoder and state timer

This block sits between the opcode fetch path and the 16-bit arithmetic unit of an 8-bit processor. It takes opcode bytes one at a time over a valid/ready pair. It follows the index prefixes and the extended prefix from one byte to the next. Once the last byte of an instruction arrives, it reports the operation, the destination register pair and the source register pair. It then walks the instruction's machine-cycle pattern one clock per state. It pulses a completion flag on the final state of the last machine cycle.

Five forms are decoded:
- pair add;
- pair add-with-carry;
- pair subtract-with-borrow;
- pair increment;
- indexed memory decrement, which also carries an 8-bit displacement.

A byte that fits no recognised form raises a one-clock illegal flag and drops any pending prefix.

Pair codes on `dst_sel` and `src_sel`:

| Code | Pair |
|------|------|
| 0 | BC |
| 1 | DE |
| 2 | HL |
| 3 | SP |
| 4 | index X |
| 5 | index Y |

Operation codes on `op_code`:

| Code | Operation |
|------|-----------|
| 1 | add |
| 2 | add-with-carry |
| 3 | subtract-with-borrow |
| 4 | increment |
| 5 | indexed decrement |

Top module: `arith16_decode`

## Requirements
- R1: After reset, `busy`, `done`, `illegal`, `m_cycle` and `t_state` are 0 and `in_ready` is 1. No prefix is pending.
- R2: With no prefix pending, a byte with bits 7:6 = 00 and bits 3:0 = 1001 starts an add (op 1). The destination is HL (2) and the source is the pair in bits 5:4. The pattern is 3 machine cycles of 4, 4 and 3 states.
- R3: Byte 0xDD selects index X (4) and byte 0xFD selects index Y (5) as a pending prefix. The prefix is held for any number of idle clocks. A following byte 00 pp 1001 starts an add (op 1) to that index register. Its source is pair pp, except that pp = 10 selects the same index register. The pattern is 4, 4, 4 and 3 states.
- R4: After byte 0xED, a byte 01 pp 1010 starts add-with-carry (op 2) and a byte 01 pp 0010 starts subtract-with-borrow (op 3). For both, the destination is HL and the source is pair pp. The pattern is 4, 4, 4 and 3 states.
- R5: With no prefix pending, a byte 00 rp 0011 starts an increment (op 4) with destination and source both equal to pair rp. The pattern is one machine cycle of 6 states.
- R6: An index prefix followed by 0x23 increments that index register (op 4, destination and source both the index register). The pattern is 4 and 6 states.
- R7: An index prefix followed by 0x35 and then a displacement byte starts an indexed decrement (op 5). The destination and source are both the index register, and `disp` carries the displacement. The pattern is 4, 4, 3, 5, 4 and 3 states.
- R8: `busy` rises on the clock after the final byte is accepted. It stays high for exactly the pattern's total state count. During that time `m_cycle` and `t_state` count from 1, and `op_code`, `dst_sel` and `src_sel` hold steady.
- R9: `done` is high for exactly one clock: the final state of the last machine cycle. The next clock is idle.
- R10: `in_ready` is low while `busy` is high. Bytes offered with `in_valid` during that time have no effect.
- R11: Several kinds of byte raise `illegal` for the one clock after they are accepted:
  - with no prefix pending, a byte that is not a prefix and not an add or increment form;
  - after an index prefix, any byte other than an add form, 0x23 or 0x35;
  - after 0xED, any byte other than an add-with-carry or subtract-with-borrow form.

  No instruction starts, and the pending prefix is cleared.
- R12: The prefix is cleared when an instruction starts, so a following 0x09 decodes as a plain add to HL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Opcode byte offered |
| in_byte | input | 8 | Opcode, prefix or displacement byte |
| in_ready | output | 1 | Byte is accepted when high |
| busy | output | 1 | An instruction pattern is running |
| done | output | 1 | Final state of the instruction |
| illegal | output | 1 | One-clock flag for an unrecognised byte |
| op_code | output | 3 | Operation code for the arithmetic unit |
| dst_sel | output | 3 | Destination pair code |
| src_sel | output | 3 | Source pair code |
| disp | output | 8 | Displacement of the indexed decrement |
| m_cycle | output | 3 | Current machine cycle, 1-based, 0 when idle |
| t_state | output | 3 | Current state within the machine cycle, 1-based, 0 when idle |

## Verification
The assertions rely on the stored state lengths never being zero and never being longer than the state counter can hold. Only the decoder loads them, from the fixed patterns, so this always holds. They also assume that a byte is only taken while `busy` is low, which the ready gating guarantees whatever the bench does with `in_valid`.

The stimulus deliberately keeps `in_valid` high through whole busy windows, and between instructions it leaves idle gaps after prefixes. This exercises the gating and prefix hold without leaving the legal input space.

// File: rtl/arith16_decode.sv
module arith16_decode #(
  parameter int MC_MAX = 6,
  parameter int TW     = 3,
  localparam int MW    = $clog2(MC_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          in_ready,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic [2:0]    op_code,
  output logic [2:0]    dst_sel,
  output logic [2:0]    src_sel,
  output logic [7:0]    disp,
  output logic [MW-1:0] m_cycle,
  output logic [TW-1:0] t_state
);

  typedef enum logic [1:0] {PF_NONE, PF_IDX, PF_EXT, PF_DISP} pf_t;

  localparam logic [2:0] OP_ADD = 3'd1;
  localparam logic [2:0] OP_ADC = 3'd2;
  localparam logic [2:0] OP_SBC = 3'd3;
  localparam logic [2:0] OP_INC = 3'd4;
  localparam logic [2:0] OP_DEC = 3'd5;
  localparam logic [2:0] PR_HL  = 3'd2;

  pf_t                      pf, d_pf;
  logic                     idx_y, d_y;
  logic [MC_MAX-1:0][TW-1:0] lens, d_len;
  logic [MW-1:0]            n_mc, d_n;
  logic                     d_start, d_bad;
  logic [2:0]               d_op, d_dst, d_src;
  logic [2:0]               idx_code;
  logic [2:0]               pp;

  assign in_ready = !busy;
  assign idx_code = idx_y ? 3'd5 : 3'd4;
  assign pp       = {1'b0, in_byte[5:4]};
  assign done     = busy && (t_state == lens[0]) && (m_cycle == n_mc);

  always_comb begin
    d_start = 1'b0;
    d_bad   = 1'b0;
    d_pf    = pf;
    d_y     = idx_y;
    d_op    = op_code;
    d_dst   = dst_sel;
    d_src   = src_sel;
    d_len   = '0;
    d_n     = '0;
    unique case (pf)
      PF_NONE: begin
        if (in_byte == 8'hDD || in_byte == 8'hFD) begin
          d_pf = PF_IDX;
          d_y  = in_byte[5];
        end else if (in_byte == 8'hED) begin
          d_pf = PF_EXT;
        end else if (in_byte[7:6] == 2'b00 && in_byte[3:0] == 4'b1001) begin
          d_start  = 1'b1;
          d_op     = OP_ADD;
          d_dst    = PR_HL;
          d_src    = pp;
          d_n      = MW'(3);
          d_len[0] = TW'(4);
          d_len[1] = TW'(4);
          d_len[2] = TW'(3);
        end else if (in_byte[7:6] == 2'b00 && in_byte[3:0] == 4'b0011) begin
          d_start  = 1'b1;
          d_op     = OP_INC;
          d_dst    = pp;
          d_src    = pp;
          d_n      = MW'(1);
          d_len[0] = TW'(6);
        end else begin
          d_bad = 1'b1;
        end
      end
      PF_IDX: begin
        if (in_byte[7:6] == 2'b00 && in_byte[3:0] == 4'b1001) begin
          d_start  = 1'b1;
          d_op     = OP_ADD;
          d_dst    = idx_code;
          d_src    = (in_byte[5:4] == 2'b10) ? idx_code : pp;
          d_n      = MW'(4);
          d_len[0] = TW'(4);
          d_len[1] = TW'(4);
          d_len[2] = TW'(4);
          d_len[3] = TW'(3);
        end else if (in_byte == 8'h23) begin
          d_start  = 1'b1;
          d_op     = OP_INC;
          d_dst    = idx_code;
          d_src    = idx_code;
          d_n      = MW'(2);
          d_len[0] = TW'(4);
          d_len[1] = TW'(6);
        end else if (in_byte == 8'h35) begin
          d_pf = PF_DISP;
        end else begin
          d_bad = 1'b1;
        end
      end
      PF_EXT: begin
        if (in_byte[7:6] == 2'b01 && (in_byte[3:0] == 4'b1010 || in_byte[3:0] == 4'b0010)) begin
          d_start  = 1'b1;
          d_op     = in_byte[3] ? OP_ADC : OP_SBC;
          d_dst    = PR_HL;
          d_src    = pp;
          d_n      = MW'(4);
          d_len[0] = TW'(4);
          d_len[1] = TW'(4);
          d_len[2] = TW'(4);
          d_len[3] = TW'(3);
        end else begin
          d_bad = 1'b1;
        end
      end
      PF_DISP: begin
        d_start  = 1'b1;
        d_op     = OP_DEC;
        d_dst    = idx_code;
        d_src    = idx_code;
        d_n      = MW'(6);
        d_len[0] = TW'(4);
        d_len[1] = TW'(4);
        d_len[2] = TW'(3);
        d_len[3] = TW'(5);
        d_len[4] = TW'(4);
        d_len[5] = TW'(3);
      end
      default: d_bad = 1'b1;
    endcase
    if (d_start || d_bad) d_pf = PF_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf      <= PF_NONE;
      idx_y   <= 1'b0;
      busy    <= 1'b0;
      illegal <= 1'b0;
      op_code <= '0;
      dst_sel <= '0;
      src_sel <= '0;
      disp    <= '0;
      m_cycle <= '0;
      t_state <= '0;
      lens    <= '0;
      n_mc    <= '0;
    end else begin
      illegal <= 1'b0;
      if (busy) begin
        if (t_state == lens[0]) begin
          if (m_cycle == n_mc) begin
            busy    <= 1'b0;
            m_cycle <= '0;
            t_state <= '0;
          end else begin
            m_cycle <= m_cycle + 1'b1;
            t_state <= TW'(1);
            lens    <= lens >> TW;
          end
        end else begin
          t_state <= t_state + 1'b1;
        end
      end else if (in_valid) begin
        pf      <= d_pf;
        idx_y   <= d_y;
        illegal <= d_bad;
        if (pf == PF_DISP) disp <= in_byte;
        if (d_start) begin
          busy    <= 1'b1;
          m_cycle <= MW'(1);
          t_state <= TW'(1);
          op_code <= d_op;
          dst_sel <= d_dst;
          src_sel <= d_src;
          lens    <= d_len;
          n_mc    <= d_n;
        end
      end
    end
  end

endmodule

// File: rtl/arith16_decode_chk.sv
module arith16_decode_chk #(
  parameter int MC_MAX = 6,
  parameter int TW     = 3,
  localparam int MW    = $clog2(MC_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [7:0]    in_byte,
  input logic          in_ready,
  input logic          busy,
  input logic          done,
  input logic          illegal,
  input logic [2:0]    op_code,
  input logic [2:0]    dst_sel,
  input logic [2:0]    src_sel,
  input logic [7:0]    disp,
  input logic [MW-1:0] m_cycle,
  input logic [TW-1:0] t_state
);

  p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);

  p_hold_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy && $stable(op_code) && $stable(dst_sel) && $stable(src_sel));

  p_start_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> m_cycle == MW'(1) && t_state == TW'(1));

  p_counters_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> m_cycle != '0 && t_state != '0 && m_cycle <= MW'(MC_MAX));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> m_cycle == '0 && t_state == '0);

  p_illegal_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy && !done);

  p_ignored_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> !illegal);

  p_ready_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

endmodule

bind arith16_decode arith16_decode_chk #(.MC_MAX(MC_MAX), .TW(TW)) u_chk (.*);

// File: tb/sim_arith16_decode.sv
module sim_arith16_decode;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready, busy, done, illegal;
  logic [2:0] op_code, dst_sel, src_sel, m_cycle, t_state;
  logic [7:0] disp;

  always #4 clk = ~clk;

  arith16_decode u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .busy(busy), .done(done), .illegal(illegal),
    .op_code(op_code), .dst_sel(dst_sel), .src_sel(src_sel), .disp(disp),
    .m_cycle(m_cycle), .t_state(t_state)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string tag = "R1";
  bit    finished = 0;

  // behavioural reference
  int mpf = 0;       // 0 none, 1 index, 2 extended, 3 waiting displacement
  int my = 0;
  bit mbusy = 0;
  bit mill = 0;
  int mmc = 0, mts = 0;
  int mop = 0, mdst = 0, msrc = 0, mdisp = 0;
  int mlens[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input int op, input int dst, input int src, input int n,
                        input int a, input int b, input int c, input int d, input int e, input int f);
    int pat[6];
    pat = '{a, b, c, d, e, f};
    mlens.delete();
    for (int i = 0; i < n; i++) mlens.push_back(pat[i]);
    mop = op; mdst = dst; msrc = src;
    mbusy = 1; mmc = 1; mts = 1; mpf = 0;
  endtask

  task automatic model_byte(input int b);
    int pair, ix;
    pair = (b >> 4) & 3;
    ix = (my != 0) ? 5 : 4;
    if (mpf == 0) begin
      if (b == 'hDD || b == 'hFD) begin mpf = 1; my = (b == 'hFD); end
      else if (b == 'hED) mpf = 2;
      else if ((b & 'hCF) == 'h09) launch(1, 2, pair, 3, 4, 4, 3, 0, 0, 0);
      else if ((b & 'hCF) == 'h03) launch(4, pair, pair, 1, 6, 0, 0, 0, 0, 0);
      else begin mill = 1; mpf = 0; end
    end else if (mpf == 1) begin
      if ((b & 'hCF) == 'h09) launch(1, ix, (pair == 2) ? ix : pair, 4, 4, 4, 4, 3, 0, 0);
      else if (b == 'h23) launch(4, ix, ix, 2, 4, 6, 0, 0, 0, 0);
      else if (b == 'h35) mpf = 3;
      else begin mill = 1; mpf = 0; end
    end else if (mpf == 2) begin
      if ((b & 'hCF) == 'h4A) launch(2, 2, pair, 4, 4, 4, 4, 3, 0, 0);
      else if ((b & 'hCF) == 'h42) launch(3, 2, pair, 4, 4, 4, 4, 3, 0, 0);
      else begin mill = 1; mpf = 0; end
    end else begin
      mdisp = b;
      launch(5, ix, ix, 6, 4, 4, 3, 5, 4, 3);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mpf = 0; my = 0; mbusy = 0; mill = 0; mmc = 0; mts = 0;
      mop = 0; mdst = 0; msrc = 0; mdisp = 0; mlens.delete();
    end else begin
      mill = 0;
      if (mbusy) begin
        if (mts == mlens[0]) begin
          if (mlens.size() == 1) begin mbusy = 0; mmc = 0; mts = 0; mlens.delete(); end
          else begin void'(mlens.pop_front()); mmc++; mts = 1; end
        end else mts++;
      end else if (in_valid) model_byte(in_byte);
    end
  end

  // per-clock comparison, 2 ns after the edge
  always @(posedge clk) begin
    bit mdone;
    #2;
    if (rst_n && !finished) begin
      mdone = mbusy && mlens.size() == 1 && mts == mlens[0];
      chk(busy == mbusy, tag, "busy", busy, mbusy);
      chk(in_ready == !mbusy, "R10", "in_ready", in_ready, !mbusy);
      chk(done == mdone, "R9", "done", done, mdone);
      chk(illegal == mill, "R11", "illegal", illegal, mill);
      chk(m_cycle == mmc, "R8", "m_cycle", m_cycle, mmc);
      chk(t_state == mts, "R8", "t_state", t_state, mts);
      if (mbusy) begin
        chk(op_code == mop, tag, "op_code", op_code, mop);
        chk(dst_sel == mdst, tag, "dst_sel", dst_sel, mdst);
        chk(src_sel == msrc, tag, "src_sel", src_sel, msrc);
        if (mop == 5) chk(disp == mdisp, "R7", "disp", disp, mdisp);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 60000);
      summary();
    end
  end

  task automatic feed(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
    idle(2);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && illegal == 0, "R1", "flags", {busy, done, illegal}, 0);
    chk(in_ready == 1, "R1", "in_ready", in_ready, 1);
    chk(m_cycle == 0 && t_state == 0, "R1", "counters", {m_cycle, t_state}, 0);

    tag = "R2";
    for (int r = 0; r < 4; r++) begin feed(8'h09 | 8'(r << 4)); settle(); end

    tag = "R5";
    for (int r = 0; r < 4; r++) begin feed(8'h03 | 8'(r << 4)); settle(); end

    tag = "R3";
    feed(8'hDD); feed(8'h09); settle();
    feed(8'hDD); feed(8'h29); settle();
    feed(8'hFD); feed(8'h19); settle();
    feed(8'hFD); feed(8'h29); settle();
    feed(8'hFD); feed(8'h39); settle();
    feed(8'hDD); idle(3); feed(8'h39); settle();

    tag = "R4";
    feed(8'hED); feed(8'h4A); settle();
    feed(8'hED); feed(8'h7A); settle();
    feed(8'hED); feed(8'h42); settle();
    feed(8'hED); feed(8'h52); settle();

    tag = "R6";
    feed(8'hDD); feed(8'h23); settle();
    feed(8'hFD); idle(2); feed(8'h23); settle();

    tag = "R7";
    feed(8'hDD); feed(8'h35); feed(8'h7F); settle();
    feed(8'hFD); feed(8'h35); idle(2); feed(8'h80); settle();

    tag = "R10";
    feed(8'h09);
    in_valid = 1'b1; in_byte = 8'hDD;
    idle(6);
    in_byte = 8'h00;
    idle(3);
    in_valid = 1'b0;
    settle();
    chk(illegal == 0, "R10", "illegal after busy bytes", illegal, 0);

    tag = "R11";
    feed(8'h00); idle(1);
    feed(8'hDD); feed(8'h00); idle(1);
    feed(8'hED); feed(8'h09); idle(1);
    feed(8'hFD); feed(8'hED); idle(1);
    feed(8'hED); feed(8'h4B); idle(1);
    tag = "R12";
    feed(8'h09); settle();
    feed(8'hDD); feed(8'h09); settle();
    feed(8'h09); settle();
    feed(8'hFD); feed(8'h35); feed(8'h01); settle();
    feed(8'h29); settle();

    idle(4);
    summary();
  end
endmodule